// File: doc/BRIEF.md
# Double-Precision Compare to Condition Field

This block compares two IEEE-754 double-precision operands, supplied as raw 64-bit patterns, and reduces the outcome to a four-bit condition code. That code replaces one chosen four-bit field of a 32-bit condition register. It is also written into the compare-result bits of the floating-point status word. The caller pulses a start strobe with the operands, a compare-kind select, a destination register index and the current condition and status words. One cycle later the block returns the updated words together with a done pulse.

Two compare kinds exist. The quiet kind reports any NaN operand as the unordered outcome. The strict kind raises an invalid-operand trap instead, and the destination register and the status word are then returned untouched. A destination index whose two low bits are not both zero is an illegal encoding. The block flags it and performs no update.

Top module: `fp_compare_cond`

## Requirements
- R1: While reset is asserted, and after it until the first start, `cr_o`, `fpscr_o`, `trap_o`, `illegal_o` and `done_o` are all zero.
- R2: `done_o` is high in exactly the cycle after each cycle in which `start_i` is high. `cr_o`, `fpscr_o`, `trap_o` and `illegal_o` hold their values between results.
- R3: An operand is NaN when its exponent field (bits 62:52) is all ones and its fraction (bits 51:0) is nonzero. Infinities compare as ordinary ordered values.
- R4: The code is one-hot: bit 3 = less-than (4'b1000), bit 2 = greater-than (4'b0100), bit 1 = equal (4'b0010), bit 0 = unordered (4'b0001). A NaN operand gives unordered. Otherwise the code gives the relation of A to B.
- R5: Ordering follows the numeric value. A negative operand orders below a positive one, negative operands order by reversed magnitude, and +0 equals −0.
- R6: Index bits [4:2] select field f, which occupies CR bits (31−4f) down to (28−4f), so field 0 is the top nibble. That field takes the code, and the other seven fields keep their input values.
- R7: In the status word, bits 15:11 are cleared and the code is written into bits 14:11. Bit 15 reads zero, and every other bit keeps its input value.
- R8: A strict compare (`ordered_i`=1) with any NaN operand sets `trap_o` and returns `cr_i` and `fpscr_i` unchanged. A quiet compare never sets `trap_o`.
- R9: If `dest_idx_i[1:0]` is nonzero, `illegal_o` is set and `cr_i` and `fpscr_i` are returned unchanged.
- R10: Trap and illegal-encoding conditions are judged independently. Both flags may assert for the same start, and the words are then unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launch a compare this cycle |
| a_i | input | 64 | Operand A bit pattern |
| b_i | input | 64 | Operand B bit pattern |
| ordered_i | input | 1 | 1 = strict compare (traps on NaN), 0 = quiet compare |
| dest_idx_i | input | 5 | Destination index; bits [4:2] pick the field, bits [1:0] must be zero |
| cr_i | input | 32 | Current condition register |
| fpscr_i | input | 32 | Current floating-point status word |
| cr_o | output | 32 | Updated condition register |
| fpscr_o | output | 32 | Updated status word |
| trap_o | output | 1 | Invalid-operand trap for a strict compare on NaN |
| illegal_o | output | 1 | Destination index had nonzero low bits |
| done_o | output | 1 | One-cycle result strobe |

## Verification
The invalid-operand trap and the illegal-destination flag can both arise from a single start. The bench provokes this by issuing strict compares with a NaN operand and a destination index whose low bits are nonzero. It expects both flags high and both words equal to their inputs. The sweep also issues back-to-back starts, to show that each result lands one cycle after its own strobe while the next compare is already being launched.

// File: rtl/fp_compare_pkg.sv
package fp_compare_pkg;

   typedef enum logic [3:0] {
      CC_UN = 4'b0001,
      CC_EQ = 4'b0010,
      CC_GT = 4'b0100,
      CC_LT = 4'b1000
   } cmp_code_e;

   typedef struct packed {
      logic is_nan;
      logic is_zero;
   } op_class_t;

endpackage

// File: rtl/fp_operand_class.sv
module fp_operand_class
   import fp_compare_pkg::*;
#(
   parameter int EXP_W  = 11,
   parameter int FRAC_W = 52
) (
   input  logic [EXP_W+FRAC_W:0] val_i,
   output op_class_t             cls_o
);
   localparam int DW = EXP_W + FRAC_W + 1;

   if (EXP_W < 2 || FRAC_W < 1) begin : g_bad_fmt
      $error("fp_operand_class: exponent and fraction widths too small");
   end

   logic [EXP_W-1:0]  exp_f;
   logic [FRAC_W-1:0] frac_f;

   assign exp_f  = val_i[DW-2 -: EXP_W];
   assign frac_f = val_i[FRAC_W-1:0];

   // Exponent all ones with a nonzero fraction is NaN; zero fraction is infinity.
   assign cls_o.is_nan  = (&exp_f) && (|frac_f);
   // Both signed zeros share a zero magnitude.
   assign cls_o.is_zero = ~|val_i[DW-2:0];
endmodule

// File: rtl/fp_order_core.sv
module fp_order_core
   import fp_compare_pkg::*;
#(
   parameter int DW        = 64,
   parameter int CMP_STYLE = 0   // 0: biased-key compare, 1: sign-magnitude compare
) (
   input  logic [DW-1:0] a_i,
   input  logic [DW-1:0] b_i,
   input  op_class_t     cls_a_i,
   input  op_class_t     cls_b_i,
   output cmp_code_e     code_o
);
   if (CMP_STYLE != 0 && CMP_STYLE != 1) begin : g_bad_style
      $error("fp_order_core: CMP_STYLE must be 0 or 1");
   end

   logic any_nan;
   logic both_zero;

   assign any_nan   = cls_a_i.is_nan | cls_b_i.is_nan;
   assign both_zero = cls_a_i.is_zero & cls_b_i.is_zero;

   if (CMP_STYLE == 0) begin : g_key
      // Map each pattern to an unsigned key that grows with the numeric value.
      logic [DW-1:0] key_a;
      logic [DW-1:0] key_b;

      assign key_a = a_i[DW-1] ? ~a_i : {1'b1, a_i[DW-2:0]};
      assign key_b = b_i[DW-1] ? ~b_i : {1'b1, b_i[DW-2:0]};

      always_comb begin
         if (any_nan)            code_o = CC_UN;
         else if (both_zero)     code_o = CC_EQ;
         else if (key_a < key_b) code_o = CC_LT;
         else if (key_a > key_b) code_o = CC_GT;
         else                    code_o = CC_EQ;
      end
   end else begin : g_signmag
      logic          sgn_a;
      logic          sgn_b;
      logic [DW-2:0] mag_a;
      logic [DW-2:0] mag_b;
      logic          mag_lt;

      assign sgn_a  = a_i[DW-1];
      assign sgn_b  = b_i[DW-1];
      assign mag_a  = a_i[DW-2:0];
      assign mag_b  = b_i[DW-2:0];
      assign mag_lt = mag_a < mag_b;

      always_comb begin
         if (any_nan)             code_o = CC_UN;
         else if (both_zero)      code_o = CC_EQ;
         else if (sgn_a != sgn_b) code_o = sgn_a ? CC_LT : CC_GT;
         else if (mag_a == mag_b) code_o = CC_EQ;
         else if (mag_lt ^ sgn_a) code_o = CC_LT;
         else                     code_o = CC_GT;
      end
   end
endmodule

// File: rtl/fp_cond_merge.sv
module fp_cond_merge #(
   parameter int CR_W    = 32,
   parameter int FIELD_W = 4,
   parameter int SEL_W   = 3,
   parameter int FS_W    = 32,
   parameter int CC_LSB  = 11
) (
   input  logic [CR_W-1:0]    cr_i,
   input  logic [FS_W-1:0]    fpscr_i,
   input  logic [SEL_W-1:0]   sel_i,
   input  logic [FIELD_W-1:0] code_i,
   input  logic               apply_i,
   output logic [CR_W-1:0]    cr_o,
   output logic [FS_W-1:0]    fpscr_o
);
   localparam int NUM_FIELDS = CR_W / FIELD_W;
   localparam int PAD_W      = FS_W - FIELD_W - 1;
   localparam logic [FS_W-1:0] CC_MASK =
      {{PAD_W{1'b0}}, {(FIELD_W+1){1'b1}}} << CC_LSB;

   if (CR_W % FIELD_W != 0) begin : g_bad_cr
      $error("fp_cond_merge: CR_W must be a multiple of FIELD_W");
   end
   if ((1 << SEL_W) != NUM_FIELDS) begin : g_bad_sel
      $error("fp_cond_merge: SEL_W does not address every field");
   end
   if (CC_LSB + FIELD_W >= FS_W) begin : g_bad_cc
      $error("fp_cond_merge: code bits fall outside the status word");
   end

   // Field k sits at the top of the word for k = 0, walking downward.
   for (genvar k = 0; k < NUM_FIELDS; k++) begin : g_field
      localparam int HI = CR_W - 1 - k * FIELD_W;
      logic hit;
      assign hit = apply_i && (sel_i == SEL_W'(k));
      assign cr_o[HI -: FIELD_W] = hit ? code_i : cr_i[HI -: FIELD_W];
   end

   logic [FS_W-1:0] code_ext;
   assign code_ext = {{(FS_W-FIELD_W){1'b0}}, code_i} << CC_LSB;

   assign fpscr_o = apply_i ? ((fpscr_i & ~CC_MASK) | code_ext) : fpscr_i;
endmodule

// File: rtl/fp_compare_cond.sv
module fp_compare_cond
   import fp_compare_pkg::*;
#(
   parameter int EXP_W     = 11,
   parameter int FRAC_W    = 52,
   parameter int CR_W      = 32,
   parameter int FIELD_W   = 4,
   parameter int FS_W      = 32,
   parameter int IDX_W     = 5,
   parameter int CC_LSB    = 11,
   parameter int CMP_STYLE = 0
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       start_i,
   input  logic [EXP_W+FRAC_W:0]      a_i,
   input  logic [EXP_W+FRAC_W:0]      b_i,
   input  logic                       ordered_i,
   input  logic [IDX_W-1:0]           dest_idx_i,
   input  logic [CR_W-1:0]            cr_i,
   input  logic [FS_W-1:0]            fpscr_i,
   output logic [CR_W-1:0]            cr_o,
   output logic [FS_W-1:0]            fpscr_o,
   output logic                       trap_o,
   output logic                       illegal_o,
   output logic                       done_o
);
   localparam int DW         = EXP_W + FRAC_W + 1;
   localparam int NUM_FIELDS = CR_W / FIELD_W;
   localparam int SEL_W      = $clog2(NUM_FIELDS);
   localparam int PAD_W      = IDX_W - SEL_W;

   if (FIELD_W != 4) begin : g_bad_field
      $error("fp_compare_cond: the one-hot code needs FIELD_W of 4");
   end
   if (PAD_W < 1) begin : g_bad_idx
      $error("fp_compare_cond: IDX_W must exceed the field-select width");
   end

   // Decode
   logic [SEL_W-1:0] field_sel;
   logic             bad_enc;
   assign field_sel = dest_idx_i[IDX_W-1 -: SEL_W];
   assign bad_enc   = |dest_idx_i[PAD_W-1:0];

   // Classification and ordering
   op_class_t cls_a;
   op_class_t cls_b;
   cmp_code_e code;

   fp_operand_class #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_a (
      .val_i(a_i), .cls_o(cls_a));
   fp_operand_class #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_b (
      .val_i(b_i), .cls_o(cls_b));

   fp_order_core #(.DW(DW), .CMP_STYLE(CMP_STYLE)) u_order (
      .a_i(a_i), .b_i(b_i), .cls_a_i(cls_a), .cls_b_i(cls_b), .code_o(code));

   logic raise_trap;
   logic apply;
   assign raise_trap = ordered_i & (cls_a.is_nan | cls_b.is_nan);
   assign apply      = ~bad_enc & ~raise_trap;

   // Merge into the architectural words
   logic [CR_W-1:0] cr_nx;
   logic [FS_W-1:0] fpscr_nx;

   fp_cond_merge #(
      .CR_W(CR_W), .FIELD_W(FIELD_W), .SEL_W(SEL_W),
      .FS_W(FS_W), .CC_LSB(CC_LSB)
   ) u_merge (
      .cr_i(cr_i), .fpscr_i(fpscr_i), .sel_i(field_sel),
      .code_i(code), .apply_i(apply),
      .cr_o(cr_nx), .fpscr_o(fpscr_nx));

   // Result register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cr_o      <= '0;
         fpscr_o   <= '0;
         trap_o    <= 1'b0;
         illegal_o <= 1'b0;
         done_o    <= 1'b0;
      end else begin
         done_o <= start_i;
         if (start_i) begin
            cr_o      <= cr_nx;
            fpscr_o   <= fpscr_nx;
            trap_o    <= raise_trap;
            illegal_o <= bad_enc;
         end
      end
   end

   // Checks on the registered result
   function automatic logic [CR_W-1:0] field_mask(input logic [SEL_W-1:0] s);
      logic [CR_W-1:0] m;
      m = '0;
      m[CR_W-1 -: FIELD_W] = '1;
      return m >> (int'(s) * FIELD_W);
   endfunction

   p_done_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> done_o);
   p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !start_i |=> !done_o);
   p_hold_between_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !start_i |=> ($stable(cr_o) && $stable(fpscr_o)));
   p_code_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !trap_o && !illegal_o) |->
         ($countones(fpscr_o[CC_LSB +: FIELD_W]) == 1 && !fpscr_o[CC_LSB+FIELD_W]));
   p_fields_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !trap_o && !illegal_o) |->
         (((cr_o ^ $past(cr_i)) & ~field_mask($past(field_sel))) == '0));
   p_trap_strict_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && trap_o) |-> $past(ordered_i));
   p_no_update_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && (illegal_o || trap_o)) |->
         (cr_o == $past(cr_i) && fpscr_o == $past(fpscr_i)));
endmodule

// File: tb/fp_compare_cond_test.sv
`timescale 1ns/1ps
module fp_compare_cond_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [63:0] a_i = '0, b_i = '0;
   logic        ordered_i = 1'b0;
   logic [4:0]  dest_idx_i = '0;
   logic [31:0] cr_i = '0, fpscr_i = '0;
   logic [31:0] cr_o, fpscr_o;
   logic        trap_o, illegal_o, done_o;

   int total = 0;
   int bad   = 0;

   always #4 clk = ~clk;

   fp_compare_cond uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .a_i(a_i), .b_i(b_i),
      .ordered_i(ordered_i), .dest_idx_i(dest_idx_i), .cr_i(cr_i),
      .fpscr_i(fpscr_i), .cr_o(cr_o), .fpscr_o(fpscr_o), .trap_o(trap_o),
      .illegal_o(illegal_o), .done_o(done_o));

   task automatic chk(input bit ok, input string tag,
                      input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [63:0] pat(input int i);
      case (i)
         0:  return 64'h0000000000000000; // +0
         1:  return 64'h8000000000000000; // -0
         2:  return 64'h3FF0000000000000; // +1
         3:  return 64'hBFF0000000000000; // -1
         4:  return 64'h4000000000000000; // +2
         5:  return 64'hC000000000000000; // -2
         6:  return 64'h7FF0000000000000; // +inf
         7:  return 64'hFFF0000000000000; // -inf
         8:  return 64'h7FF8000000000000; // quiet NaN
         9:  return 64'h7FF0000000000001; // signalling NaN
         10: return 64'hFFF8000000000000; // negative NaN
         11: return 64'h0000000000000001; // +denormal
         12: return 64'h8000000000000001; // -denormal
         13: return 64'h7FEFFFFFFFFFFFFF; // +max
         14: return 64'hFFEFFFFFFFFFFFFF; // -max
         default: return 64'h3FF8000000000000; // +1.5
      endcase
   endfunction

   function automatic bit nan_of(input logic [63:0] v);
      return (v[62:52] == 11'h7FF) && (v[51:0] != 0);
   endfunction

   function automatic logic [3:0] ref_code(input logic [63:0] a, input logic [63:0] b);
      real ra, rb;
      if (nan_of(a) || nan_of(b)) return 4'b0001;
      ra = $bitstoreal(a);
      rb = $bitstoreal(b);
      if (ra == rb) return 4'b0010;
      if (ra < rb)  return 4'b1000;
      return 4'b0100;
   endfunction

   function automatic logic [31:0] ref_cr(input logic [31:0] cr, input int f,
                                          input logic [3:0] c);
      logic [31:0] r;
      r = cr;
      r[31 - 4*f -: 4] = c;
      return r;
   endfunction

   function automatic logic [31:0] ref_fs(input logic [31:0] fs, input logic [3:0] c);
      return (fs & ~32'h0000F800) | ({28'd0, c} << 11);
   endfunction

   task automatic drive(input logic [63:0] a, input logic [63:0] b, input bit ord,
                        input logic [4:0] d, input logic [31:0] cr, input logic [31:0] fs);
      a_i = a; b_i = b; ordered_i = ord; dest_idx_i = d; cr_i = cr; fpscr_i = fs;
   endtask

   task automatic run_op(input logic [63:0] a, input logic [63:0] b, input bit ord,
                         input logic [4:0] d, input logic [31:0] cr, input logic [31:0] fs);
      @(negedge clk);
      drive(a, b, ord, d, cr, fs);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   initial begin
      #(8 * 150000);
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [31:0] cr0, fs0, hold_cr;
      logic [3:0]  c;

      // R1: reset state
      repeat (3) @(negedge clk);
      chk({cr_o, fpscr_o, trap_o, illegal_o, done_o} == '0, "R1 reset outputs",
          {cr_o, fpscr_o}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk({cr_o, fpscr_o, trap_o, illegal_o, done_o} == '0, "R1 idle after reset",
          {cr_o, fpscr_o}, 64'd0);

      // R3 R4 R5 R6 R7 R8: sweep over every operand pair, both compare kinds
      for (int i = 0; i < 16; i++) begin
         for (int j = 0; j < 16; j++) begin
            for (int m = 0; m < 2; m++) begin
               int f;
               bit any_nan;
               f   = (i + j + m) % 8;
               cr0 = 32'hA5C30F96 ^ (i * 32'h01010101) ^ (j << 7);
               fs0 = 32'h7FFFFFFF ^ (j * 32'h00000911) ^ (i << 12);
               run_op(pat(i), pat(j), m[0], 5'(f << 2), cr0, fs0);
               c = ref_code(pat(i), pat(j));
               any_nan = nan_of(pat(i)) || nan_of(pat(j));
               chk(done_o == 1'b1, "R2 done after start", 64'(done_o), 64'd1);
               chk(illegal_o == 1'b0, "R9 legal index", 64'(illegal_o), 64'd0);
               if (any_nan && m == 1) begin
                  chk(trap_o == 1'b1, "R8 strict NaN traps", 64'(trap_o), 64'd1);
                  chk(cr_o == cr0 && fpscr_o == fs0, "R8 no update on trap",
                      {cr_o, fpscr_o}, {cr0, fs0});
               end else begin
                  chk(trap_o == 1'b0, "R8 no trap", 64'(trap_o), 64'd0);
                  chk(cr_o == ref_cr(cr0, f, c), "R4 R5 R6 cr field",
                      64'(cr_o), 64'(ref_cr(cr0, f, c)));
                  chk(fpscr_o == ref_fs(fs0, c), "R3 R7 status code",
                      64'(fpscr_o), 64'(ref_fs(fs0, c)));
               end
            end
         end
      end

      // R2: outputs hold and done drops when no start follows
      hold_cr = cr_o;
      drive(pat(2), pat(3), 1'b0, 5'd0, 32'h12345678, 32'h0);
      @(negedge clk);
      chk(done_o == 1'b0, "R2 single pulse", 64'(done_o), 64'd0);
      chk(cr_o == hold_cr, "R2 hold without start", 64'(cr_o), 64'(hold_cr));

      // R2: back-to-back starts, each result one cycle after its strobe
      @(negedge clk);
      drive(pat(3), pat(2), 1'b0, 5'd0, 32'h00000000, 32'h00000000);
      start_i = 1'b1;
      @(negedge clk);
      drive(pat(2), pat(3), 1'b0, 5'd28, 32'hFFFFFFFF, 32'hFFFFFFFF);
      chk(done_o && cr_o == 32'h80000000, "R2 first of pair", 64'(cr_o), 64'h80000000);
      @(negedge clk);
      start_i = 1'b0;
      chk(done_o && cr_o == 32'hFFFFFFF4 && fpscr_o == 32'hFFFF27FF,
          "R2 second of pair", {cr_o, fpscr_o}, {32'hFFFFFFF4, 32'hFFFF27FF});
      @(negedge clk);
      chk(done_o == 1'b0, "R2 pair ends", 64'(done_o), 64'd0);

      // R9: nonzero low index bits
      for (int k = 1; k < 4; k++) begin
         run_op(pat(2), pat(4), 1'b0, 5'(8 + k), 32'hDEADBEEF, 32'h0F0F0F0F);
         chk(illegal_o == 1'b1 && trap_o == 1'b0, "R9 illegal flagged",
             {illegal_o, trap_o}, 64'd2);
         chk(cr_o == 32'hDEADBEEF && fpscr_o == 32'h0F0F0F0F, "R9 no update",
             {cr_o, fpscr_o}, {32'hDEADBEEF, 32'h0F0F0F0F});
      end

      // R10: trap and illegal encoding from the same start
      for (int k = 1; k < 4; k++) begin
         run_op(pat(8 + k - 1), pat(2), 1'b1, 5'(k), 32'h13579BDF, 32'h2468ACE0);
         chk(illegal_o == 1'b1 && trap_o == 1'b1, "R10 both flags",
             {illegal_o, trap_o}, 64'd3);
         chk(cr_o == 32'h13579BDF && fpscr_o == 32'h2468ACE0, "R10 no update",
             {cr_o, fpscr_o}, {32'h13579BDF, 32'h2468ACE0});
      end

      // R8: quiet compare with NaN after a trap clears the trap flag
      run_op(pat(9), pat(9), 1'b0, 5'd4, 32'h0, 32'h0000F800);
      chk(trap_o == 1'b0 && cr_o == 32'h01000000 && fpscr_o == 32'h00000800,
          "R8 quiet NaN unordered", {cr_o, fpscr_o}, {32'h01000000, 32'h00000800});

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule